// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A small synchronous static memory whose address, selection, write and advance inputs are all captured on the rising clock edge. One captured address opens a burst of four beats. An internal two-bit beat counter supplies the addresses after the first beat. A mode input sets the beat order. In linear order the two low address bits count upward and wrap. In interleaved order they are the start value XORed with the beat number. The upper address bits do not change during a burst.

Every access passes through one register stage before it reaches the array. Read data therefore appears after the edge that follows the capturing edge. A write can cover the whole 36-bit word, or only the 9-bit lanes picked by active-low lane selects under a byte-write enable. Read data goes to the pins only while the asynchronous output enable is low. A deselecting cycle stops output one clock after it is captured. A sleep input makes the block ignore every access cycle while it is high.

The high-impedance state is shown by the `dout_drive` flag. When that flag is low, `dout` is held at zero.

Top module: `burst_sram`

## Requirements
- R1: A cycle with `start_n` low and the chip selected opens a burst. The chip is selected when `ce_n`=0, `sel_hi`=1 and `sel_lo_n`=0. Beat 0 of the burst accesses `addr` exactly.
- R2: With `lin_order`=1, the low two address bits of beat b are (start + b) mod 4.
- R3: With `lin_order`=0, the low two address bits of beat b are start XOR b.
- R4: In an open burst, a cycle with `start_n` high and `adv_n` low moves to the next beat. A cycle with `adv_n` high repeats the access at the current beat.
- R5: Read data for an access captured at edge k appears on `dout` after edge k+1, and `dout_drive` is 1 then.
- R6: `gw_n`=0 writes all four lanes from `din`, whatever `bwe_n` and `bsel_n` are.
- R7: With `gw_n`=1 and `bwe_n`=0, only the lanes whose `bsel_n` bit is 0 are written. Lane i is bits 9i+8..9i. Write cycles produce no output.
- R8: A cycle with `start_n` low and the chip not selected closes the burst. Output is off one clock after that cycle is captured, and later advance cycles perform no access.
- R9: `oe_n`=1 forces `dout_drive`=0 and `dout`=0 at once, without waiting for a clock edge.
- R10: While `sleep`=1 no access is made. No write takes place and the burst position is kept.
- R11: After reset, `dout_drive` is 0 and no burst is open.
- R12: The address bits above bit 1 stay equal to those of the opening address for the whole burst.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Opening address of a burst |
| ce_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| start_n | input | 1 | Start strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| lin_order | input | 1 | 1 = linear order, 0 = interleaved order |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write select, active low |
| sleep | input | 1 | Power-down; blocks accesses |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_drive | output | 1 | 1 when the data bus is driven |

## Verification
Two things can happen in the same cycle: the capture of a deselect or sleep cycle, and the delivery of a read beat captured one edge earlier. The bench provokes this by ending read bursts with a deselect, a sleep or a write straight after an advance. The last beat must still appear, and output must stop only on the following cycle. A second overlap is a write's array update landing in the same edge as the next cycle's capture. Random mixed traffic exercises it, and a behavioural memory model judges it by comparing `dout` and `dout_drive` on every clock.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  // what a captured cycle does to the burst state
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_DESEL = 3'd2,
    OP_STEP  = 3'd3,
    OP_HOLD  = 3'd4
  } burst_op_e;

  // low address bits of a given beat in either order
  function automatic logic [1:0] beat_offset(input logic lin,
                                             input logic [1:0] first,
                                             input logic [1:0] beat);
    return lin ? 2'(first + beat) : (first ^ beat);
  endfunction

endpackage

// File: rtl/pbs_cmd_decode.sv
module pbs_cmd_decode
  import pbs_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             sleep,
  input  logic             start_n,
  input  logic             ce_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output burst_op_e        op,
  output logic             wr,
  output logic [LANES-1:0] mask
);

  logic chosen;

  assign chosen = !ce_n && sel_hi && !sel_lo_n;

  always_comb begin
    if (sleep)         op = OP_NONE;
    else if (!start_n) op = chosen ? OP_LOAD : OP_DESEL;
    else if (!adv_n)   op = OP_STEP;
    else               op = OP_HOLD;
  end

  // global write wins over the per-lane path
  always_comb begin
    wr = !gw_n || !bwe_n;
    if (!gw_n)       mask = '1;
    else if (!bwe_n) mask = ~bsel_n;
    else             mask = '0;
  end

endmodule

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
  import pbs_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  burst_op_e     op,
  input  logic          lin,
  input  logic [AW-1:0] ld_addr,
  output logic          acc_en,
  output logic [AW-1:0] acc_addr
);

  localparam int unsigned UW = AW - 2;

  logic          act_q;
  logic [UW-1:0] upper_q;
  logic [1:0]    first_q;
  logic [1:0]    beat_q;

  always_comb begin
    acc_en   = 1'b0;
    acc_addr = ld_addr;
    unique case (op)
      OP_LOAD: begin
        acc_en   = 1'b1;
        acc_addr = ld_addr;
      end
      OP_STEP: begin
        acc_en   = act_q;
        acc_addr = {upper_q, beat_offset(lin, first_q, 2'(beat_q + 2'd1))};
      end
      OP_HOLD: begin
        acc_en   = act_q;
        acc_addr = {upper_q, beat_offset(lin, first_q, beat_q)};
      end
      default: acc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      upper_q <= '0;
      first_q <= 2'd0;
      beat_q  <= 2'd0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          act_q   <= 1'b1;
          upper_q <= ld_addr[AW-1:2];
          first_q <= ld_addr[1:0];
          beat_q  <= 2'd0;
        end
        OP_DESEL: act_q <= 1'b0;
        OP_STEP:  if (act_q) beat_q <= 2'(beat_q + 2'd1);
        default:  ;
      endcase
    end
  end

  // R12
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && op != OP_LOAD) |=> $stable(upper_q));

  // R4
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD || op == OP_NONE) |=> $stable(beat_q));

  // R2
  lin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && op == OP_STEP && lin) ##1 (op == OP_STEP && lin)
      |-> acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1));

  // R3
  intl_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && op == OP_STEP && !lin) ##1 (op == OP_STEP && !lin)
      |-> acc_addr[0] != $past(acc_addr[0]));

endmodule

// File: rtl/pbs_lane_mem.sv
module pbs_lane_mem #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  // one simple-port array per lane so each maps to its own block RAM
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re)    rd_q <= store[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import pbs_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           addr,
  input  logic                    ce_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    start_n,
  input  logic                    adv_n,
  input  logic                    lin_order,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drive
);

  localparam int unsigned DW = LANES * LANE_W;

  burst_op_e        op;
  logic             dec_wr;
  logic [LANES-1:0] dec_mask;
  logic             acc_en;
  logic [AW-1:0]    acc_addr;

  logic             s1_valid;
  logic             s1_wr;
  logic [LANES-1:0] s1_mask;
  logic [AW-1:0]    s1_addr;
  logic [DW-1:0]    s1_data;
  logic             rd_valid_q;
  logic [DW-1:0]    rdata;

  pbs_cmd_decode #(.LANES(LANES)) dec_i (
    .sleep    (sleep),
    .start_n  (start_n),
    .ce_n     (ce_n),
    .sel_hi   (sel_hi),
    .sel_lo_n (sel_lo_n),
    .adv_n    (adv_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bsel_n   (bsel_n),
    .op       (op),
    .wr       (dec_wr),
    .mask     (dec_mask)
  );

  pbs_burst_seq #(.AW(AW)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .lin      (lin_order),
    .ld_addr  (addr),
    .acc_en   (acc_en),
    .acc_addr (acc_addr)
  );

  // capture stage: every access waits here one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_wr    <= 1'b0;
      s1_mask  <= '0;
    end else begin
      s1_valid <= acc_en;
      s1_wr    <= dec_wr;
      s1_mask  <= dec_mask;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= acc_addr;
    s1_data <= din;
  end

  pbs_lane_mem #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
    .clk   (clk),
    .we    ((s1_valid && s1_wr) ? s1_mask : '0),
    .re    (s1_valid && !s1_wr),
    .addr  (s1_addr),
    .wdata (s1_data),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= s1_valid && !s1_wr;
  end

  // output enable gates the bus without a clock
  assign dout_drive = rd_valid_q && !oe_n;
  assign dout       = dout_drive ? rdata : '0;

  // R10
  sleep_block_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !s1_valid);

  // R5
  read_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_wr) |=> rd_valid_q);

  // R8
  desel_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !start_n && !(!ce_n && sel_hi && !sel_lo_n)) |=> ##1 !rd_valid_q);

  // R6
  global_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !gw_n && acc_en) |=> (s1_wr && s1_mask == '1));

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  localparam int AW     = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << AW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic             ce_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic             start_n = 1'b1, adv_n = 1'b1, lin_order = 1'b1;
  logic             gw_n = 1'b1, bwe_n = 1'b1;
  logic [LANES-1:0] bsel_n = '1;
  logic             sleep = 1'b0, oe_n = 1'b0;
  logic [DW-1:0]    din = '0;
  logic [DW-1:0]    dout;
  logic             dout_drive;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .start_n(start_n), .adv_n(adv_n),
    .lin_order(lin_order), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .sleep(sleep), .oe_n(oe_n), .din(din), .dout(dout),
    .dout_drive(dout_drive)
  );

  // behavioural reference
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_open;
  int            m_upper, m_first, m_beat;
  bit            p_valid, p_wr;
  logic [LANES-1:0] p_mask;
  int            p_addr;
  logic [DW-1:0] p_data;
  bit            o_valid;
  logic [DW-1:0] o_data;

  function automatic int low_bits(bit lin, int first, int beat);
    return lin ? ((first + beat) % 4) : (first ^ beat);
  endfunction

  task automatic model_reset();
    m_open = 0; m_beat = 0; p_valid = 0; o_valid = 0; o_data = '0;
  endtask

  task automatic model_edge();
    bit nv; int na; bit chosen;
    if (p_valid && p_wr) begin
      for (int i = 0; i < LANES; i++)
        if (p_mask[i]) ref_mem[p_addr][i*LANE_W +: LANE_W] = p_data[i*LANE_W +: LANE_W];
    end else if (p_valid) begin
      o_data = ref_mem[p_addr];
    end
    o_valid = p_valid && !p_wr;
    nv = 0; na = 0;
    chosen = !ce_n && sel_hi && !sel_lo_n;
    if (!sleep) begin
      if (!start_n) begin
        if (chosen) begin
          m_open = 1; m_upper = int'(addr) / 4; m_first = int'(addr) % 4;
          m_beat = 0; nv = 1; na = int'(addr);
        end else m_open = 0;
      end else if (m_open) begin
        if (!adv_n) m_beat = (m_beat + 1) % 4;
        nv = 1; na = m_upper * 4 + low_bits(lin_order, m_first, m_beat);
      end
    end
    p_valid = nv;
    p_addr  = na;
    p_wr    = !gw_n || !bwe_n;
    p_mask  = !gw_n ? '1 : (!bwe_n ? ~bsel_n : '0);
    p_data  = din;
  endtask

  task automatic compare(string tag);
    bit exp_drv;
    logic [DW-1:0] exp_d;
    exp_drv = o_valid && !oe_n;
    exp_d   = exp_drv ? o_data : '0;
    n_checks++;
    if (dout_drive !== exp_drv || dout !== exp_d) begin
      n_fails++;
      $display("FAIL %s: drive=%0b dout=%h expected drive=%0b dout=%h at %0t",
               tag, dout_drive, dout, exp_drv, exp_d, $time);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    start_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = '1;
    ce_n = 0; sel_hi = 1; sel_lo_n = 0; sleep = 0; oe_n = 0;
  endtask

  task automatic open_read(int a, string tag);
    quiet(); start_n = 0; addr = AW'(a); tick(tag);
  endtask

  task automatic step(string tag);
    quiet(); adv_n = 0; tick(tag);
  endtask

  task automatic idle(int n, string tag);
    quiet();
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    // R11: nothing driven right after reset, advance does nothing
    compare("R11");
    step("R11");
    step("R11");

    // fill with global writes, one opening per word (R1, R6)
    for (int a = 0; a < DEPTH; a++) begin
      quiet(); start_n = 0; addr = AW'(a); gw_n = 0;
      din = {4'(a), 32'(a * 32'h9e37_79b9)};
      tick("R6");
    end
    idle(2, "R6");
    // global write overrides lane path
    quiet(); start_n = 0; addr = 6'd5; gw_n = 0; bwe_n = 0; bsel_n = 4'b1110;
    din = 36'h5_5555_5555; tick("R6");
    idle(1, "R6");
    open_read(5, "R6"); idle(2, "R6");

    // linear bursts from every offset (R1, R2, R5)
    for (int s = 0; s < 4; s++) begin
      lin_order = 1;
      open_read(16 + s, "R1");
      for (int b = 0; b < 3; b++) begin quiet(); adv_n = 0; lin_order = 1; tick("R2"); end
      idle(2, "R5");
    end
    // interleaved bursts from every offset (R3)
    for (int s = 0; s < 4; s++) begin
      lin_order = 0;
      open_read(40 + s, "R3");
      for (int b = 0; b < 4; b++) begin quiet(); adv_n = 0; lin_order = 0; tick("R3"); end
      idle(2, "R3");
    end
    // top group, burst stays inside it (R12)
    lin_order = 1;
    open_read(DEPTH - 2, "R12");
    for (int b = 0; b < 5; b++) step("R12");
    lin_order = 0;
    open_read(DEPTH - 3, "R12");
    for (int b = 0; b < 5; b++) step("R12");
    idle(2, "R12");

    // hold with advance high (R4)
    lin_order = 1;
    open_read(9, "R4");
    step("R4");
    quiet(); tick("R4"); tick("R4");
    step("R4"); step("R4");
    idle(2, "R4");

    // byte-lane writes across a burst, then read back (R7)
    quiet(); start_n = 0; addr = 6'd20; bwe_n = 0; bsel_n = 4'b1010;
    din = 36'hA_BCDE_F012; tick("R7");
    quiet(); adv_n = 0; bwe_n = 0; bsel_n = 4'b0111; din = 36'h1_2345_6789; tick("R7");
    quiet(); adv_n = 0; bwe_n = 0; bsel_n = 4'b1111; din = 36'hF_FFFF_FFFF; tick("R7");
    quiet(); adv_n = 0; bwe_n = 0; bsel_n = 4'b0000; din = 36'h3_0303_0303; tick("R7");
    quiet(); bwe_n = 0; bsel_n = 4'b1101; din = 36'h0_0FF0_0FF0; tick("R7");
    open_read(20, "R7");
    for (int b = 0; b < 3; b++) step("R7");
    idle(2, "R7");

    // deselect straight after a beat (R8)
    open_read(28, "R8"); step("R8");
    quiet(); start_n = 0; ce_n = 1; tick("R8");
    step("R8"); step("R8"); idle(1, "R8");
    open_read(29, "R8");
    quiet(); start_n = 0; sel_hi = 0; tick("R8");
    step("R8"); idle(1, "R8");
    open_read(30, "R8");
    quiet(); start_n = 0; sel_lo_n = 1; tick("R8");
    step("R8"); idle(1, "R8");

    // asynchronous output enable (R9)
    open_read(33, "R9");
    for (int b = 0; b < 4; b++) begin
      step("R9");
      oe_n = 1; #1 compare("R9");
      oe_n = 0; #1 compare("R9");
    end
    idle(2, "R9");

    // sleep mid burst, with writes attempted (R10)
    open_read(44, "R10"); step("R10");
    quiet(); sleep = 1; adv_n = 0; gw_n = 0; din = '0; tick("R10");
    quiet(); sleep = 1; start_n = 0; addr = 6'd1; gw_n = 0; tick("R10");
    step("R10"); step("R10");
    open_read(1, "R10"); idle(2, "R10");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 16;
      quiet();
      start_n   = (r < 4) ? 1'b0 : 1'b1;
      adv_n     = ($urandom % 4 == 0);
      ce_n      = ($urandom % 8 == 0);
      lin_order = ($urandom % 2 == 0);
      gw_n      = ($urandom % 6 != 0);
      bwe_n     = ($urandom % 5 != 0);
      bsel_n    = LANES'($urandom);
      sleep     = ($urandom % 20 == 0);
      oe_n      = ($urandom % 7 == 0);
      addr      = AW'($urandom);
      din       = {4'($urandom), 32'($urandom)};
      tick("MIX");
    end
    idle(2, "MIX");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #500000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule